// File: doc/BRIEF.md
# Card Clock Generator with Bypass

This block derives the clock sent to a memory card from the master clock. A programmable even divider produces a card clock whose period is twice the divider value in master cycles. A divider value of zero hands the master clock straight to the card. The block also turns the requested bus width into a lane-enable mask. It raises a high-speed flag for the faster single-rate modes, and in the fastest single-rate mode it chooses the feedback clock, returned by an external delay line, as the receive sampling clock.

Every control input is captured in one register stage. Double-data-rate mode never allows the pass-through path: a zero divider becomes a divider of one. A request for zero frequency while powered applies the largest divider and keeps the clock running. A new divider value only starts at the rising edge that follows a full low phase, so the card never sees a shortened pulse. Power-off holds the card clock low. The actual-divider report reads zero whenever power is off.

Top module: `cardclk_gen`

## Requirements
- R1: With a nonzero effective divider N, the card clock stays high for exactly N master cycles and low for exactly N master cycles.
- R2: With divider field 0, DDR off and no stop request, the card clock follows the master clock (bypass) while power is on.
- R3: With DDR on and divider field 0, the effective divider is 1: phases of one master cycle, actualDiv reads 1 and actualBypass reads 0.
- R4: A stop request while power is on applies the largest divider (all ones), taking priority over the divider field and DDR, and the card clock keeps toggling.
- R5: laneMask follows widthSel: code 0 gives 8'h01, code 1 gives 8'h0F, code 2 gives 8'hFF, and the unused code 3 gives 8'h01.
- R6: sampleFb is 1 only when speedMode is 3 (fastest single-rate) and DDR is off; otherwise 0 (internal clock).
- R7: busSpeedHigh is 1 when speedMode is 2 or 3 and 0 for codes 0 and 1.
- R8: A divider change made during a high phase leaves that high phase and the following low phase at the old length; the new length starts with the next high phase.
- R9: With powerOn low, the card clock is held low.
- R10: actualDiv reports the effective divider and actualBypass reports the bypass condition while powerOn is high; both read zero while powerOn is low.
- R11: During reset the card clock is low, actualDiv and actualBypass are 0, laneMask is 8'h01 and sampleFb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerOn | input | 1 | Power state is on |
| divReq | input | DIV_W | Requested divider field, 0 selects bypass |
| stopReq | input | 1 | Request for zero frequency |
| ddrEn | input | 1 | Double-data-rate mode |
| widthSel | input | 2 | Bus width code: 0 one lane, 1 four lanes, 2 eight lanes |
| speedMode | input | 2 | Speed code: 0 normal, 1 fast, 2 single-rate mid, 3 single-rate top |
| cardClk | output | 1 | Clock to the card |
| sampleFb | output | 1 | 1 selects the feedback clock for receive sampling |
| busSpeedHigh | output | 1 | High-speed bus timing flag |
| laneMask | output | 8 | Data lane enables |
| actualDiv | output | DIV_W | Effective divider when powered, else 0 |
| actualBypass | output | 1 | Bypass active when powered, else 0 |

## Verification
The bench builds the block with DIV_W=6, so the stop request drives the largest divider of 63. A full 126-cycle card clock period at that value is then short enough to measure phase by phase. Divider values of 1, 3, 6 and 7 show both the narrowest phases and the mid-phase change rule. The bypass case is checked by sampling the card clock on both halves of the master clock.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

  typedef enum logic [1:0] {
    WID_ONE   = 2'd0,
    WID_FOUR  = 2'd1,
    WID_EIGHT = 2'd2,
    WID_RSVD  = 2'd3
  } widthSel_e;

  typedef enum logic [1:0] {
    SPD_NORMAL  = 2'd0,
    SPD_FAST    = 2'd1,
    SPD_SDR_MID = 2'd2,
    SPD_SDR_TOP = 2'd3
  } speed_e;

  typedef struct packed {
    logic run;        // power on, divider may toggle
    logic bypassReq;  // pass master clock straight through
  } ctrlStrobe_t;

endpackage

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
  import ckg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerOn,
  input  logic [DIV_W-1:0] divReq,
  input  logic             stopReq,
  input  logic             ddrEn,
  input  widthSel_e        widthSel,
  input  speed_e           speedMode,
  output ctrlStrobe_t      strobe,
  output logic [DIV_W-1:0] divNext,
  output logic [7:0]       laneMask,
  output logic             sampleFb,
  output logic             busSpeedHigh,
  output logic [DIV_W-1:0] actualDiv,
  output logic             actualBypass
);

  localparam logic [DIV_W-1:0] DIV_MAX = '1;
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] effDiv;
  logic             effBypass;
  logic [7:0]       laneNext;

  always_comb begin
    if (stopReq)                      effDiv = DIV_MAX;
    else if (divReq == '0 && ddrEn)   effDiv = DIV_ONE;
    else                              effDiv = divReq;
    effBypass = (effDiv == '0);
  end

  always_comb begin
    case (widthSel)
      WID_FOUR:  laneNext = 8'h0F;
      WID_EIGHT: laneNext = 8'hFF;
      default:   laneNext = 8'h01;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe       <= '0;
      divNext      <= DIV_MAX;
      laneMask     <= 8'h01;
      sampleFb     <= 1'b0;
      busSpeedHigh <= 1'b0;
      actualDiv    <= '0;
      actualBypass <= 1'b0;
    end else begin
      strobe.run       <= powerOn;
      strobe.bypassReq <= powerOn && effBypass;
      divNext          <= effDiv;
      laneMask         <= laneNext;
      sampleFb         <= (speedMode == SPD_SDR_TOP) && !ddrEn;
      busSpeedHigh     <= (speedMode == SPD_SDR_MID) || (speedMode == SPD_SDR_TOP);
      actualDiv        <= powerOn ? effDiv : '0;
      actualBypass     <= powerOn && effBypass;
    end
  end

  p_ddr_no_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
    ddrEn |=> !strobe.bypassReq);

  p_stop_max_div_r4: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (divNext == DIV_MAX));

  p_lane_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({1'b0, laneMask} + 9'd1));

  p_fb_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleFb |-> ($past(speedMode) == SPD_SDR_TOP && !$past(ddrEn)));

  p_actual_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |=> (actualDiv == '0 && !actualBypass));

endmodule

// File: rtl/ckg_datapath.sv
module ckg_datapath
  import ckg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [DIV_W-1:0] divNext,
  output logic             cardClk
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divCur;
  logic [DIV_W-1:0] divLoad;
  logic             divClk;
  logic             bypSel;
  logic             holdLow;
  logic [DIV_W:0]   hiLen;

  // a zero divider never reaches the counter
  assign divLoad = (divNext == '0) ? divCur : divNext;
  assign holdLow = (strobe.bypassReq || bypSel) && !divClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divClk <= 1'b0;
      divCur <= '1;
    end else if (!strobe.run) begin
      cnt    <= '0;
      divClk <= 1'b0;
      divCur <= divLoad;
    end else if (holdLow) begin
      cnt    <= '0;
      divCur <= divLoad;
    end else if (cnt == divCur - DIV_ONE) begin
      cnt    <= '0;
      divClk <= !divClk;
      if (!divClk) divCur <= divLoad;  // new length starts with a high phase
    end else begin
      cnt <= cnt + DIV_ONE;
    end
  end

  // bypass select moves only while both clock sources are low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)        bypSel <= 1'b0;
    else if (!divClk) bypSel <= strobe.bypassReq && strobe.run;
  end

  assign cardClk = bypSel ? clk : divClk;

  // high-phase length tracker for the checker below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hiLen <= '0;
    else if (!divClk)          hiLen <= (DIV_W+1)'(1);
    else                       hiLen <= hiLen + (DIV_W+1)'(1);
  end

  p_full_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(divClk) && $past(strobe.run)) |-> ($past(hiLen) == {1'b0, $past(divCur)}));

  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    bypSel |-> !divClk);

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> !divClk);

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import ckg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerOn,
  input  logic [DIV_W-1:0] divReq,
  input  logic             stopReq,
  input  logic             ddrEn,
  input  logic [1:0]       widthSel,
  input  logic [1:0]       speedMode,
  output logic             cardClk,
  output logic             sampleFb,
  output logic             busSpeedHigh,
  output logic [7:0]       laneMask,
  output logic [DIV_W-1:0] actualDiv,
  output logic             actualBypass
);

  ctrlStrobe_t      strobe;
  logic [DIV_W-1:0] divNext;

  ckg_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .powerOn      (powerOn),
    .divReq       (divReq),
    .stopReq      (stopReq),
    .ddrEn        (ddrEn),
    .widthSel     (widthSel_e'(widthSel)),
    .speedMode    (speed_e'(speedMode)),
    .strobe       (strobe),
    .divNext      (divNext),
    .laneMask     (laneMask),
    .sampleFb     (sampleFb),
    .busSpeedHigh (busSpeedHigh),
    .actualDiv    (actualDiv),
    .actualBypass (actualBypass)
  );

  ckg_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .divNext (divNext),
    .cardClk (cardClk)
  );

endmodule

// File: tb/cardclk_gen_tb_top.sv
module cardclk_gen_tb_top;

  localparam int DIV_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             powerOn = 1'b1;
  logic [DIV_W-1:0] divReq = DIV_W'(3);
  logic             stopReq = 1'b0;
  logic             ddrEn = 1'b0;
  logic [1:0]       widthSel = 2'd0;
  logic [1:0]       speedMode = 2'd0;
  logic             cardClk, sampleFb, busSpeedHigh, actualBypass;
  logic [7:0]       laneMask;
  logic [DIV_W-1:0] actualDiv;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = !clk;

  cardclk_gen #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .divReq(divReq),
    .stopReq(stopReq), .ddrEn(ddrEn), .widthSel(widthSel),
    .speedMode(speedMode), .cardClk(cardClk), .sampleFb(sampleFb),
    .busSpeedHigh(busSpeedHigh), .laneMask(laneMask),
    .actualDiv(actualDiv), .actualBypass(actualBypass)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // sample card clock after each master falling edge
  task automatic sampleCk(output logic v);
    @(negedge clk);
    #1;
    v = cardClk;
  endtask

  task automatic waitRise(output bit ok);
    logic prev, cur;
    ok = 1'b0;
    sampleCk(prev);
    for (int i = 0; i < 400; i++) begin
      sampleCk(cur);
      if (!prev && cur) begin ok = 1'b1; break; end
      prev = cur;
    end
  endtask

  task automatic countRun(logic lvl, input int already, output int n);
    logic v;
    n = already;
    for (int i = 0; i < 400; i++) begin
      sampleCk(v);
      if (v != lvl) break;
      n++;
    end
  endtask

  // measures one full cycle: high length then low length
  task automatic measure(output int hi, output int lo);
    bit ok;
    waitRise(ok);
    if (!ok) begin hi = 0; lo = 0; return; end
    countRun(1'b1, 1, hi);
    countRun(1'b0, 1, lo);
  endtask

  task automatic settledPhases(string req, int expN);
    int hi, lo;
    measure(hi, lo);
    measure(hi, lo);
    check({req, " high"}, hi, expN);
    check({req, " low"}, lo, expN);
  endtask

  task automatic testReset();
    #1;
    check("R11 cardClk", int'(cardClk), 0);
    check("R11 actualDiv", int'(actualDiv), 0);
    check("R11 actualBypass", int'(actualBypass), 0);
    check("R11 laneMask", int'(laneMask), 1);
    check("R11 sampleFb", int'(sampleFb), 0);
  endtask

  task automatic testDivide();
    divReq = 6'd3; settledPhases("R1 div3", 3);
    check("R10 actualDiv3", int'(actualDiv), 3);
    divReq = 6'd1; settledPhases("R1 div1", 1);
    divReq = 6'd7; settledPhases("R1 div7", 7);
    check("R10 actualDiv7", int'(actualDiv), 7);
  endtask

  task automatic testBypass();
    divReq = 6'd0;
    idle(20);
    check("R10 actualBypass", int'(actualBypass), 1);
    check("R10 actualDiv0", int'(actualDiv), 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      check("R2 bypass high half", int'(cardClk), 1);
      @(negedge clk); #5;
      check("R2 bypass low half", int'(cardClk), 0);
    end
  endtask

  task automatic testDdr();
    divReq = 6'd0;
    ddrEn = 1'b1;
    settledPhases("R3 ddr zero div", 1);
    check("R3 actualDiv", int'(actualDiv), 1);
    check("R3 actualBypass", int'(actualBypass), 0);
    ddrEn = 1'b0;
  endtask

  task automatic testStop();
    divReq = 6'd2;
    ddrEn = 1'b1;
    stopReq = 1'b1;
    settledPhases("R4 stop max div", 63);
    check("R4 actualDiv", int'(actualDiv), 63);
    stopReq = 1'b0;
    ddrEn = 1'b0;
  endtask

  task automatic testLanes();
    int expMask[4] = '{1, 15, 255, 1};
    for (int c = 0; c < 4; c++) begin
      widthSel = 2'(c);
      idle(3);
      check($sformatf("R5 width code %0d", c), int'(laneMask), expMask[c]);
    end
    widthSel = 2'd0;
  endtask

  task automatic testSpeed();
    speedMode = 2'd3; ddrEn = 1'b0; idle(3);
    check("R6 top single-rate fb", int'(sampleFb), 1);
    check("R7 top speed flag", int'(busSpeedHigh), 1);
    ddrEn = 1'b1; idle(3);
    check("R6 ddr keeps internal", int'(sampleFb), 0);
    ddrEn = 1'b0; speedMode = 2'd2; idle(3);
    check("R6 mid speed internal", int'(sampleFb), 0);
    check("R7 mid speed flag", int'(busSpeedHigh), 1);
    speedMode = 2'd1; idle(3);
    check("R7 fast flag low", int'(busSpeedHigh), 0);
    speedMode = 2'd0;
  endtask

  task automatic testMidChange();
    int hi, lo;
    bit ok;
    divReq = 6'd3;
    settledPhases("R1 pre-change", 3);
    waitRise(ok);
    divReq = 6'd6;  // changed during the high phase
    countRun(1'b1, 1, hi);
    countRun(1'b0, 1, lo);
    check("R8 current high keeps old", hi, 3);
    check("R8 next low keeps old", lo, 3);
    countRun(1'b1, 1, hi);
    countRun(1'b0, 1, lo);
    check("R8 new high", hi, 6);
    check("R8 new low", lo, 6);
  endtask

  task automatic testPowerOff();
    int highs = 0;
    logic v;
    divReq = 6'd2;
    powerOn = 1'b0;
    idle(6);
    for (int i = 0; i < 20; i++) begin
      sampleCk(v);
      if (v) highs++;
    end
    check("R9 clock held low", highs, 0);
    check("R10 actualDiv off", int'(actualDiv), 0);
    divReq = 6'd0;
    idle(3);
    check("R9 bypass off low", int'(cardClk), 0);
    check("R10 actualBypass off", int'(actualBypass), 0);
    powerOn = 1'b1;
    divReq = 6'd2;
    settledPhases("R1 after power on", 2);
  endtask

  initial begin
    #150000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    testDivide();
    testBypass();
    testDdr();
    testStop();
    testLanes();
    testSpeed();
    testMidChange();
    testPowerOff();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule